// File: doc/BRIEF.md
# Security Attribution Region Lookup

This block decides, for any 32-bit address, whether an access to it is secure, non-secure, or secure but callable from the non-secure state. Software programs a small table of address regions through a plain address/data/write-enable port. Each region has a base register and a limit register. A two-bit control word picks between three modes: everything secure, everything non-secure, or classification by the region table.

The lookup itself is combinational. It takes the address, a flag marking an instruction fetch, and the security state of the requester, and returns four things: a non-secure flag, a callable flag, the number of the matching region, and a flag saying that region number is valid. Two kinds of address skip the table. A fetch from the top address segment is always secure. A fixed set of system windows follows the requester's own state. When an address falls in more than one enabled region, it falls back to a plain secure result with no region number.

Top module: `sec_attr_lookup`

## Requirements
- R1: After reset every base, limit and control register is zero, so every address outside the exempt windows (and every fetch from the top segment) is secure, not callable, with region-valid clear and region number 0.
- R2: The control word has enable in bit 0 and all-non-secure in bit 1. With enable clear, a non-exempt address reads non-secure exactly when all-non-secure is set, and it is never callable. With enable set, the region table decides.
- R3: A region covers, inclusively, from its base register with bits 4:0 forced to 0 up to its limit register with bits 4:0 forced to 1.
- R4: A region takes part in matching only while bit 0 of its limit register is 1. Bit 1 of the limit register makes a hit read callable instead of non-secure.
- R5: When the table is enabled and exactly one region matches, the block reports either non-secure or callable (never both), sets region-valid and outputs that region's index.
- R6: When two or more enabled regions match, the result is secure, not callable, region number 0 and region-valid clear.
- R7: When the table is enabled and no region matches a non-exempt address, the result is secure, not callable, region number 0 and region-valid clear.
- R8: An instruction fetch with address bits 31:28 equal to 4'hF is secure, not callable and not valid, whatever the control word and the table hold.
- R9: Addresses in E0000000–E0002FFF, E000E000–E000EFFF, E002E000–E002EFFF, E0040000–E0041FFF and E00FF000–E00FFFFF (hex, inclusive) bypass the table and the control word. For these, non-secure is the inverse of req_secure, callable is 0, and region-valid is 0. An instruction fetch from 0xF… still follows R8.
- R10: A write uses wr_addr[1:0] as the register kind: 0 is the base, 1 is the limit, 2 is the control word (region field ignored), and 3 changes nothing. wr_addr[WA-1:2] selects the region. A write takes effect at the clock edge on which wr_en is sampled high.
- R11: The outputs follow addr, is_fetch and req_secure combinationally, in the same cycle, from the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register file |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(NREG)+2 | Region index in the upper bits, register kind in bits 1:0 |
| wr_data | input | 32 | Write data |
| addr | input | 32 | Address to classify |
| is_fetch | input | 1 | Access is an instruction fetch |
| req_secure | input | 1 | Requester is currently secure |
| attr_ns | output | 1 | Address is non-secure |
| attr_nsc | output | 1 | Address is secure and non-secure-callable |
| attr_region | output | $clog2(NREG) | Index of the single matching region, else 0 |
| attr_region_valid | output | 1 | attr_region names a single matching region |

## Verification
The classification outputs are due in the same cycle as their inputs. The bench therefore drives addr, is_fetch and req_secure just after a falling edge and samples one nanosecond later, long before the next rising edge. A register write is due one edge later. The bench raises wr_en at a falling edge and checks, before the following rising edge, that the old classification still holds. It checks again just after that edge, where the new one must appear. Each sweep runs a fixed set of boundary and stride addresses under all four combinations of fetch and requester state, against a model kept from the bench's own record of what it wrote.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

    localparam int ADDR_W    = 32;
    localparam int GRAN_BITS = 5;

    // register kind carried in the low two bits of the write address
    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } sel_code_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_ALLNS_BIT = 1;
    localparam int LIM_EN_BIT     = 0;
    localparam int LIM_NSC_BIT    = 1;

    // fetches from this top nibble are always secure
    localparam logic [3:0] FETCH_SEC_TOP = 4'hF;

    // fixed windows that bypass the region table
    localparam int NWIN = 5;
    localparam logic [NWIN-1:0][ADDR_W-1:0] WIN_LO = {
        32'hE00F_F000, 32'hE004_0000, 32'hE002_E000, 32'hE000_E000, 32'hE000_0000
    };
    localparam logic [NWIN-1:0][ADDR_W-1:0] WIN_HI = {
        32'hE00F_FFFF, 32'hE004_1FFF, 32'hE002_EFFF, 32'hE000_EFFF, 32'hE000_2FFF
    };

    typedef struct packed {
        logic ns;
        logic nsc;
        logic valid;
    } attr_flags_t;

endpackage

// File: rtl/sar_regfile.sv
module sar_regfile
    import sec_attr_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int RIDX_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [RIDX_W-1:0]             wr_ridx,
    input  sel_code_e                     wr_code,
    input  logic [ADDR_W-1:0]             wr_data,
    output logic [NREG-1:0][ADDR_W-1:0]   base_q,
    output logic [NREG-1:0][ADDR_W-1:0]   limit_q,
    output logic [1:0]                    ctrl_q
);

    typedef struct packed {
        logic [NREG-1:0][ADDR_W-1:0] base;
        logic [NREG-1:0][ADDR_W-1:0] limit;
        logic [1:0]                  ctrl;
    } rf_t;

    rf_t st_d;
    rf_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_code)
                SEL_BASE: begin
                    for (int r = 0; r < NREG; r++) begin
                        if (wr_ridx == RIDX_W'(r)) begin
                            st_d.base[r] = wr_data;
                        end
                    end
                end
                SEL_LIMIT: begin
                    for (int r = 0; r < NREG; r++) begin
                        if (wr_ridx == RIDX_W'(r)) begin
                            st_d.limit[r] = wr_data;
                        end
                    end
                end
                SEL_CTRL: begin
                    st_d.ctrl = wr_data[1:0];
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_q  = st_q.base;
    assign limit_q = st_q.limit;
    assign ctrl_q  = st_q.ctrl;

endmodule

// File: rtl/sar_region_match.sv
module sar_region_match
    import sec_attr_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NREG-1:0][ADDR_W-1:0] base,
    input  logic [NREG-1:0][ADDR_W-1:0] limit,
    output logic [NREG-1:0]             hit,
    output logic [NREG-1:0]             nsc_mark
);

    localparam int HI_W = ADDR_W - GRAN_BITS;

    for (genvar g = 0; g < NREG; g++) begin : g_region
        logic [ADDR_W-1:0] lo_edge;
        logic [ADDR_W-1:0] hi_edge;
        logic              unused_low;

        assign lo_edge    = {base[g][ADDR_W-1:GRAN_BITS], {GRAN_BITS{1'b0}}};
        assign hi_edge    = {limit[g][ADDR_W-1:GRAN_BITS], {GRAN_BITS{1'b1}}};
        assign hit[g]     = limit[g][LIM_EN_BIT]
                          && (addr >= lo_edge) && (addr <= hi_edge);
        assign nsc_mark[g] = limit[g][LIM_NSC_BIT];
        assign unused_low = ^{base[g][GRAN_BITS-1:0], limit[g][GRAN_BITS-1:2]};
    end

    localparam int UNUSED_HI_W = HI_W;

endmodule

// File: rtl/sar_exempt_decode.sv
module sar_exempt_decode
    import sec_attr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              exempt
);

    logic [NWIN-1:0] in_win;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign in_win[w] = (addr >= WIN_LO[w]) && (addr <= WIN_HI[w]);
    end

    assign exempt = |in_win;

endmodule

// File: rtl/sar_resolve.sv
module sar_resolve
    import sec_attr_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int RIDX_W = 3
) (
    input  logic [NREG-1:0]   hit,
    input  logic [NREG-1:0]   nsc_mark,
    input  logic [1:0]        ctrl,
    input  logic              exempt,
    input  logic              fetch_top,
    input  logic              req_secure,
    output attr_flags_t       flags,
    output logic [RIDX_W-1:0] region
);

    logic [RIDX_W-1:0] idx;
    logic              any_hit;
    logic              multi_hit;
    logic              nsc_hit;

    // index of the highest hit; only used when exactly one hit exists
    always_comb begin
        idx = '0;
        for (int r = 0; r < NREG; r++) begin
            if (hit[r]) begin
                idx = RIDX_W'(r);
            end
        end
    end

    assign any_hit   = |hit;
    assign multi_hit = |(hit & (hit - NREG'(1)));
    assign nsc_hit   = |(hit & nsc_mark);

    always_comb begin
        flags  = '0;
        region = '0;
        if (fetch_top) begin
            flags = '0;
        end else if (exempt) begin
            flags.ns = !req_secure;
        end else if (!ctrl[CTRL_EN_BIT]) begin
            flags.ns = ctrl[CTRL_ALLNS_BIT];
        end else if (any_hit && !multi_hit) begin
            flags.ns    = !nsc_hit;
            flags.nsc   = nsc_hit;
            flags.valid = 1'b1;
            region      = idx;
        end
    end

endmodule

// File: rtl/sec_attr_lookup.sv
module sec_attr_lookup
    import sec_attr_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    parameter int WA     = RIDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA-1:0]     wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [31:0]       addr,
    input  logic              is_fetch,
    input  logic              req_secure,
    output logic              attr_ns,
    output logic              attr_nsc,
    output logic [RIDX_W-1:0] attr_region,
    output logic              attr_region_valid
);

    logic [NREG-1:0][ADDR_W-1:0] base_q;
    logic [NREG-1:0][ADDR_W-1:0] limit_q;
    logic [1:0]                  ctrl_q;
    logic [NREG-1:0]             hit;
    logic [NREG-1:0]             nsc_mark;
    logic                        exempt;
    logic                        fetch_top;
    attr_flags_t                 flags;
    sel_code_e                   wr_code;

    assign wr_code   = sel_code_e'(wr_addr[1:0]);
    assign fetch_top = is_fetch && (addr[ADDR_W-1:ADDR_W-4] == FETCH_SEC_TOP);

    sar_regfile #(.NREG(NREG), .RIDX_W(RIDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ridx (wr_addr[WA-1:2]),
        .wr_code (wr_code),
        .wr_data (wr_data),
        .base_q  (base_q),
        .limit_q (limit_q),
        .ctrl_q  (ctrl_q)
    );

    sar_region_match #(.NREG(NREG)) u_match (
        .addr     (addr),
        .base     (base_q),
        .limit    (limit_q),
        .hit      (hit),
        .nsc_mark (nsc_mark)
    );

    sar_exempt_decode u_exempt (
        .addr   (addr),
        .exempt (exempt)
    );

    sar_resolve #(.NREG(NREG), .RIDX_W(RIDX_W)) u_resolve (
        .hit        (hit),
        .nsc_mark   (nsc_mark),
        .ctrl       (ctrl_q),
        .exempt     (exempt),
        .fetch_top  (fetch_top),
        .req_secure (req_secure),
        .flags      (flags),
        .region     (attr_region)
    );

    assign attr_ns           = flags.ns;
    assign attr_nsc          = flags.nsc;
    assign attr_region_valid = flags.valid;

endmodule

// File: rtl/sec_attr_lookup_chk.sv
module sec_attr_lookup_chk #(
    parameter int RIDX_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_code,
    input logic [1:0]        wr_ctrl,
    input logic [31:0]       addr,
    input logic              is_fetch,
    input logic [1:0]        ctrl,
    input logic              attr_ns,
    input logic              attr_nsc,
    input logic [RIDX_W-1:0] attr_region,
    input logic              attr_region_valid
);

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(attr_ns && attr_nsc));

    assert_valid_has_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        attr_region_valid |-> (attr_ns || attr_nsc));

    assert_invalid_region_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_region_valid |-> (attr_region == '0));

    assert_fetch_top_secure_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fetch && addr[31:28] == 4'hF) |-> (!attr_ns && !attr_nsc && !attr_region_valid));

    assert_callable_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_nsc || attr_region_valid) |-> ctrl[0]);

    assert_ctrl_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code == 2'd2) |=> (ctrl == $past(wr_ctrl)));

    assert_ctrl_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_code == 2'd2) |=> $stable(ctrl));

endmodule

bind sec_attr_lookup sec_attr_lookup_chk #(.RIDX_W(RIDX_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .wr_en             (wr_en),
    .wr_code           (wr_addr[1:0]),
    .wr_ctrl           (wr_data[1:0]),
    .addr              (addr),
    .is_fetch          (is_fetch),
    .ctrl              (ctrl_q),
    .attr_ns           (attr_ns),
    .attr_nsc          (attr_nsc),
    .attr_region       (attr_region),
    .attr_region_valid (attr_region_valid)
);

// File: tb/sec_attr_lookup_test.sv
module sec_attr_lookup_test;

    localparam int NR = 4;
    localparam int RW = 2;
    localparam int WA = RW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [WA-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   addr = '0;
    logic          is_fetch = 1'b0;
    logic          req_secure = 1'b0;
    logic          attr_ns;
    logic          attr_nsc;
    logic [RW-1:0] attr_region;
    logic          attr_region_valid;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_base [NR];
    logic [31:0] m_lim  [NR];
    logic [1:0]  m_ctrl;

    always #10 clk = ~clk;

    sec_attr_lookup #(.NREG(NR)) uut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .addr (addr), .is_fetch (is_fetch),
        .req_secure (req_secure), .attr_ns (attr_ns), .attr_nsc (attr_nsc),
        .attr_region (attr_region), .attr_region_valid (attr_region_valid)
    );

    localparam logic [31:0] PTS [34] = '{
        32'h0000_0000, 32'h0FFF_FFFF, 32'h1000_0000, 32'h1000_07FF, 32'h1000_0800,
        32'h1000_0FFF, 32'h1000_1000, 32'h1000_1FFF, 32'h1000_2000, 32'h2000_0000,
        32'h2000_003F, 32'h2000_0040, 32'h2000_009F, 32'h2000_00A0, 32'hDFFF_FFFF,
        32'hE000_0000, 32'hE000_2FFF, 32'hE000_3000, 32'hE000_DFFF, 32'hE000_E000,
        32'hE000_EFFF, 32'hE000_F000, 32'hE002_DFFF, 32'hE002_E000, 32'hE002_EFFF,
        32'hE003_FFFF, 32'hE004_0000, 32'hE004_1FFF, 32'hE004_2000, 32'hE00F_F000,
        32'hE00F_FFFF, 32'hE010_0000, 32'hF000_0000, 32'hFFFF_FFFF
    };

    function automatic logic in_window(logic [31:0] a);
        return (a >= 32'hE000_0000 && a <= 32'hE000_2FFF) ||
               (a >= 32'hE000_E000 && a <= 32'hE000_EFFF) ||
               (a >= 32'hE002_E000 && a <= 32'hE002_EFFF) ||
               (a >= 32'hE004_0000 && a <= 32'hE004_1FFF) ||
               (a >= 32'hE00F_F000 && a <= 32'hE00F_FFFF);
    endfunction

    task automatic check_one(string req, logic [31:0] a, logic f, logic s);
        logic e_ns, e_nsc, e_v;
        logic [RW-1:0] e_r;
        int cnt, last;
        logic last_nsc;
        @(negedge clk);
        addr = a; is_fetch = f; req_secure = s;
        #1;
        e_ns = 0; e_nsc = 0; e_v = 0; e_r = '0;
        cnt = 0; last = 0; last_nsc = 0;
        if (f && a[31:28] == 4'hF) begin
        end else if (in_window(a)) begin
            e_ns = !s;
        end else if (!m_ctrl[0]) begin
            e_ns = m_ctrl[1];
        end else begin
            for (int r = 0; r < NR; r++) begin
                if (m_lim[r][0] && a >= (m_base[r] & 32'hFFFF_FFE0)
                                && a <= (m_lim[r] | 32'h0000_001F)) begin
                    cnt++; last = r; last_nsc = m_lim[r][1];
                end
            end
            if (cnt == 1) begin
                e_ns = !last_nsc; e_nsc = last_nsc; e_v = 1; e_r = RW'(last);
            end
        end
        n_chk++;
        if ({attr_ns, attr_nsc, attr_region_valid, attr_region} !== {e_ns, e_nsc, e_v, e_r}) begin
            n_fail++;
            $display("FAIL %s addr=%h fetch=%0d sec=%0d got ns/nsc/v/r=%b%b%b/%0d exp=%b%b%b/%0d",
                     req, a, f, s, attr_ns, attr_nsc, attr_region_valid, attr_region,
                     e_ns, e_nsc, e_v, e_r);
        end
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < 34; i++) begin
            for (int c = 0; c < 4; c++) check_one(req, PTS[i], c[1], c[0]);
        end
        for (int i = 0; i < 16; i++) begin
            for (int c = 0; c < 4; c++)
                check_one(req, (32'(i) << 28) | 32'h0ABC_DE50, c[1], c[0]);
        end
    endtask

    task automatic wr_reg(int r, logic [1:0] code, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = {RW'(r), code}; wr_data = d;
        @(posedge clk);
        #1 wr_en = 0;
        case (code)
            2'd0: m_base[r] = d;
            2'd1: m_lim[r]  = d;
            2'd2: m_ctrl    = d[1:0];
            default: ;
        endcase
    endtask

    task automatic expect_bit(string req, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    initial begin
        #100000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin m_base[r] = '0; m_lim[r] = '0; end
        m_ctrl = 2'b00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state, R9 exempt windows, R8 fetch top, R11 same-cycle outputs
        sweep("R1/R9/R8/R11");

        // R10 timing: control write lands on the edge it is sampled
        @(negedge clk);
        addr = 32'h3000_0000; is_fetch = 0; req_secure = 1;
        wr_en = 1; wr_addr = {RW'(0), 2'd2}; wr_data = 32'h0000_0002;
        #1 expect_bit("R10 before edge", attr_ns, 1'b0);
        @(posedge clk);
        #1 wr_en = 0; m_ctrl = 2'b10;
        expect_bit("R10 after edge", attr_ns, 1'b1);

        // R2 all non-secure while disabled
        sweep("R2/R8/R9");

        // program regions, still disabled: table ignored (R2)
        wr_reg(0, 2'd0, 32'h1000_0000);
        wr_reg(0, 2'd1, 32'h1000_0FE1);
        wr_reg(1, 2'd0, 32'h2000_005F);
        wr_reg(1, 2'd1, 32'h2000_0083);
        wr_reg(2, 2'd0, 32'h1000_0800);
        wr_reg(2, 2'd1, 32'h1000_1FE1);
        wr_reg(3, 2'd0, 32'h2000_0000);
        wr_reg(3, 2'd1, 32'h2000_FFFE);
        wr_reg(0, 2'd2, 32'h0000_0000);
        sweep("R2 disabled-secure");

        // enable the table: R3 bounds, R4 enable/callable, R5 single, R6 overlap, R7 miss
        wr_reg(0, 2'd2, 32'h0000_0001);
        sweep("R3/R4/R5/R6/R7");

        // code 3 writes change nothing (R10)
        wr_reg(0, 2'd3, 32'hFFFF_FFFF);
        wr_reg(3, 2'd3, 32'h0000_0000);
        sweep("R10 code3");

        // enabled + all-non-secure: table still decides (R2)
        wr_reg(0, 2'd2, 32'h0000_0003);
        sweep("R2 enable-wins");

        // region covering exempt windows and top segment (R8, R9); disable r2 overlap
        wr_reg(3, 2'd0, 32'hE000_0000);
        wr_reg(3, 2'd1, 32'hFFFF_FFE1);
        wr_reg(2, 2'd1, 32'h1000_1FE0);
        sweep("R8/R9/R5 region over windows");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule